// File: doc/BRIEF.md
# Two-Level Trigger Sample Buffer

This block takes a continuous stream of digitized calorimeter samples and keeps every one of them in a circular history memory. Each accepted sample advances a free-running sample clock, and that count serves as the sample's timestamp. When a first-level (L0) trigger names a timestamp, the block waits until the whole window around that time has been written. It then copies the window into one fixed-size slot of a linear event memory. Each copied word carries a byte of per-sample flag bits that marks it as L0-selected.

Stored events wait in arrival order for a second-level (L1) decision. An accept sends the event out as a framed packet on a valid/ready stream: a header word, then the window samples in time order, with a last marker on the final word. A reject releases the slot without output. If no slot is free, or a capture is still in progress, a new L0 trigger is dropped and counted. The slot count must be a power of two, and the ring must be deeper than the window plus the trigger latency.

Top module: `trig_sample_buf`

## Requirements
- R1: Every cycle with `smp_valid` high writes `smp_data` into a ring of `RING_DEPTH` entries, overwriting the oldest. The sample takes as its timestamp a `TW`-bit counter that starts at 0 after reset and advances once per valid sample.
- R2: An L0 trigger at timestamp T, once stored and released, yields the `PRE+POST+1` samples with timestamps T-PRE through T+POST, oldest first.
- R3: Each output data word is {flag byte, sample}. Flag bit 0 is set on every window word (L0 selected), flag bit 1 is set only on the sample at T, and all other flag bits are 0.
- R4: A stored event produces no output until an L1 accept for it is taken.
- R5: An L1 reject for the oldest undecided event frees its slot and produces no output words.
- R6: An L1 decision is ignored when no stored event is undecided, or when `l1_evnum` differs from the number of the oldest undecided event.
- R7: An L0 trigger that arrives while a capture is running, or while all `NSLOT` slots are held, is dropped, and `ovf_count` increments by exactly 1.
- R8: A released event is framed as one header word followed by `PRE+POST+1` data words, with `out_last` high only on the final data word. The header is {8'hE0 in the flag byte, 4-bit event number in bits 15:12, 12-bit trigger timestamp in bits 11:0}.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: Stored events are numbered 0, 1, 2, … modulo 16 in capture order. Dropped triggers take no number.
- R11: After reset, `out_valid` and `out_last` are low and `ovf_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_data | input | DW (16) | Digitized sample |
| l0_valid | input | 1 | L0 trigger strobe |
| l0_time | input | TW (12) | Timestamp at the centre of the L0 window |
| l1_valid | input | 1 | L1 decision strobe |
| l1_evnum | input | EW (4) | Event number the decision refers to |
| l1_accept | input | 1 | 1 = accept and send, 0 = reject and discard |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | FW+DW (24) | Header or flagged sample word |
| out_last | output | 1 | Final word of the event |
| ovf_count | output | OVW (8) | Count of dropped L0 triggers |

## Verification
An L0 trigger whose window is already written is copied within `PRE+POST+3` cycles. `ovf_count` moves on the edge after a dropped strobe. The header of an accepted event becomes valid after the second rising edge following the L1 strobe, and each later word is valid two cycles after the previous handshake. The bench changes inputs on falling edges and reads outputs 1 ns later. Every handshake goes into a queue, so frame content is checked against the expected word list without depending on the exact cycle a word appeared. Checks that nothing happened, such as held events, rejects and ignored decisions, wait 40 cycles, well past these latencies, before they sample.

// File: rtl/tsb_pkg.sv
`timescale 1ns/1ps
package tsb_pkg;
  typedef enum logic [1:0] {CAP_IDLE, CAP_WAIT, CAP_COPY} cap_state_t;
  typedef enum logic [1:0] {EM_IDLE, EM_HOLD, EM_FETCH} emit_state_t;
  localparam int FLAG_SEL_BIT  = 0;
  localparam int FLAG_TRIG_BIT = 1;
endpackage

// File: rtl/tsb_sdp_ram.sv
`timescale 1ns/1ps
module tsb_sdp_ram #(
  parameter int W = 16,
  parameter int D = 64,
  localparam int AW = $clog2(D)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tsb_capture.sv
`timescale 1ns/1ps
module tsb_capture
  import tsb_pkg::*;
#(
  parameter int TW   = 12,
  parameter int RAW  = 6,
  parameter int PRE  = 2,
  parameter int POST = 3,
  localparam int WIN = PRE + POST + 1,
  localparam int KW  = $clog2(WIN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [TW-1:0]  start_ts,
  input  logic [TW-1:0]  now,
  output logic           busy,
  output logic           ring_re,
  output logic [RAW-1:0] ring_raddr,
  output logic           lin_we,
  output logic [KW-1:0]  lin_idx,
  output logic           lin_trig,
  output logic           done,
  output logic [TW-1:0]  ts_q
);
  cap_state_t    st;
  logic [KW-1:0] k;
  logic [TW-1:0] age;
  logic [TW-1:0] first_ts;
  logic [TW-1:0] rd_ts;

  assign age        = now - ts_q;
  assign first_ts   = ts_q - TW'(PRE);
  assign rd_ts      = first_ts + TW'(k);
  assign ring_re    = (st == CAP_COPY);
  assign ring_raddr = rd_ts[RAW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= CAP_IDLE;
      k        <= '0;
      ts_q     <= '0;
      lin_we   <= 1'b0;
      lin_idx  <= '0;
      lin_trig <= 1'b0;
    end else begin
      // ring read data lands one cycle later; the write side follows it
      lin_we   <= ring_re;
      lin_idx  <= k;
      lin_trig <= (k == KW'(PRE));
      case (st)
        CAP_IDLE: if (start) begin
          ts_q <= start_ts;
          st   <= CAP_WAIT;
        end
        CAP_WAIT: if (age > TW'(POST)) begin
          k  <= '0;
          st <= CAP_COPY;
        end
        CAP_COPY: begin
          k <= k + 1'b1;
          if (k == KW'(WIN - 1)) st <= CAP_IDLE;
        end
        default: st <= CAP_IDLE;
      endcase
    end
  end

  assign done = lin_we && (lin_idx == KW'(WIN - 1));
  assign busy = (st != CAP_IDLE) || lin_we;
endmodule

// File: rtl/tsb_emit.sv
`timescale 1ns/1ps
module tsb_emit
  import tsb_pkg::*;
#(
  parameter int OW  = 24,
  parameter int WIN = 6,
  localparam int KW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pend,
  input  logic          pend_acc,
  input  logic [OW-1:0] hdr,
  input  logic [OW-1:0] rd_q,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [OW-1:0] out_data,
  output logic          out_last,
  output logic          rd_re,
  output logic [KW-1:0] rd_idx,
  output logic          release_o
);
  emit_state_t   st;
  logic [KW-1:0] idx;
  logic          fire;

  assign fire      = out_valid && out_ready;
  assign rd_re     = fire && !out_last && (st == EM_HOLD);
  assign rd_idx    = idx;
  assign release_o = ((st == EM_IDLE) && pend && !pend_acc) || (fire && out_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= EM_IDLE;
      idx       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      case (st)
        EM_IDLE: if (pend && pend_acc) begin
          out_valid <= 1'b1;
          out_data  <= hdr;
          out_last  <= 1'b0;
          idx       <= '0;
          st        <= EM_HOLD;
        end
        EM_HOLD: if (fire) begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          st        <= out_last ? EM_IDLE : EM_FETCH;
        end
        EM_FETCH: begin
          out_valid <= 1'b1;
          out_data  <= rd_q;
          out_last  <= (idx == KW'(WIN - 1));
          idx       <= idx + 1'b1;
          st        <= EM_HOLD;
        end
        default: st <= EM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trig_sample_buf.sv
`timescale 1ns/1ps
module trig_sample_buf
  import tsb_pkg::*;
#(
  parameter int DW         = 16,
  parameter int FW         = 8,
  parameter int TW         = 12,
  parameter int EW         = 4,
  parameter int RING_DEPTH = 64,
  parameter int PRE        = 2,
  parameter int POST       = 3,
  parameter int NSLOT      = 4,
  parameter int OVW        = 8,
  parameter logic [FW-1:0] HDR_TAG = 'hE0,
  localparam int OW     = DW + FW,
  localparam int RAW    = $clog2(RING_DEPTH),
  localparam int WIN    = PRE + POST + 1,
  localparam int KW     = $clog2(WIN + 1),
  localparam int SW     = $clog2(NSLOT),
  localparam int PW     = SW + 1,
  localparam int LDEPTH = NSLOT * WIN,
  localparam int LAW    = $clog2(LDEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_valid,
  input  logic [DW-1:0]  smp_data,
  input  logic           l0_valid,
  input  logic [TW-1:0]  l0_time,
  input  logic           l1_valid,
  input  logic [EW-1:0]  l1_evnum,
  input  logic           l1_accept,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [OW-1:0]  out_data,
  output logic           out_last,
  output logic [OVW-1:0] ovf_count
);
  // sample clock and ring
  logic [TW-1:0] wcnt;
  logic [DW-1:0] ring_q;
  logic          ring_re;
  logic [RAW-1:0] ring_raddr;

  // slot pointers: written (wp), decided (dp), released (rp)
  logic [PW-1:0] wp, dp, rp;
  logic [EW-1:0] evcnt;
  logic [EW-1:0] ev_num [NSLOT];
  logic [TW-1:0] ev_ts  [NSLOT];
  logic [NSLOT-1:0] acc;

  logic          busy, full, l0_take, l0_drop, l1_hit;
  logic          lin_we, lin_trig, done;
  logic [KW-1:0] lin_idx, rd_idx;
  logic [TW-1:0] ts_q;
  logic [FW-1:0] flg;
  logic [LAW-1:0] lin_waddr, lin_raddr;
  logic [OW-1:0] lin_q, hdr;
  logic          rd_re, release_pulse;
  logic [SW-1:0] wslot, dslot, rslot;

  assign wslot   = wp[SW-1:0];
  assign dslot   = dp[SW-1:0];
  assign rslot   = rp[SW-1:0];
  assign full    = (wp - rp) == PW'(NSLOT);
  assign l0_take = l0_valid && !busy && !full;
  assign l0_drop = l0_valid && (busy || full);
  assign l1_hit  = l1_valid && (wp != dp) && (l1_evnum == ev_num[dslot]);

  always_comb begin
    flg                = '0;
    flg[FLAG_SEL_BIT]  = 1'b1;
    flg[FLAG_TRIG_BIT] = lin_trig;
  end

  assign lin_waddr = LAW'(wslot) * LAW'(WIN) + LAW'(lin_idx);
  assign lin_raddr = LAW'(rslot) * LAW'(WIN) + LAW'(rd_idx);
  assign hdr       = {HDR_TAG, DW'({ev_num[rslot], ev_ts[rslot]})};

  tsb_sdp_ram #(.W(DW), .D(RING_DEPTH)) u_ring (
    .clk(clk), .we(smp_valid), .waddr(wcnt[RAW-1:0]), .wdata(smp_data),
    .re(ring_re), .raddr(ring_raddr), .rdata(ring_q)
  );

  tsb_capture #(.TW(TW), .RAW(RAW), .PRE(PRE), .POST(POST)) u_cap (
    .clk(clk), .rst(rst), .start(l0_take), .start_ts(l0_time), .now(wcnt),
    .busy(busy), .ring_re(ring_re), .ring_raddr(ring_raddr),
    .lin_we(lin_we), .lin_idx(lin_idx), .lin_trig(lin_trig),
    .done(done), .ts_q(ts_q)
  );

  tsb_sdp_ram #(.W(OW), .D(LDEPTH)) u_lin (
    .clk(clk), .we(lin_we), .waddr(lin_waddr), .wdata({flg, ring_q}),
    .re(rd_re), .raddr(lin_raddr), .rdata(lin_q)
  );

  tsb_emit #(.OW(OW), .WIN(WIN)) u_emit (
    .clk(clk), .rst(rst), .pend(rp != dp), .pend_acc(acc[rslot]),
    .hdr(hdr), .rd_q(lin_q), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .rd_re(rd_re), .rd_idx(rd_idx), .release_o(release_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt      <= '0;
      wp        <= '0;
      dp        <= '0;
      rp        <= '0;
      evcnt     <= '0;
      acc       <= '0;
      ovf_count <= '0;
    end else begin
      if (smp_valid) wcnt <= wcnt + 1'b1;
      if (l0_drop) ovf_count <= ovf_count + 1'b1;
      if (done) begin
        ev_num[wslot] <= evcnt;
        ev_ts[wslot]  <= ts_q;
        evcnt         <= evcnt + 1'b1;
        wp            <= wp + 1'b1;
      end
      if (l1_hit) begin
        acc[dslot] <= l1_accept;
        dp         <= dp + 1'b1;
      end
      if (release_pulse) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/tsb_chk.sv
`timescale 1ns/1ps
module tsb_chk #(
  parameter int DW   = 16,
  parameter int FW   = 8,
  parameter int PRE  = 2,
  parameter int POST = 3,
  parameter int OVW  = 8,
  parameter logic [FW-1:0] HDR_TAG = 'hE0,
  localparam int OW  = DW + FW,
  localparam int WIN = PRE + POST + 1,
  localparam int CW  = $clog2(WIN + 2)
) (
  input logic           clk,
  input logic           rst,
  input logic           out_valid,
  input logic           out_ready,
  input logic [OW-1:0]  out_data,
  input logic           out_last,
  input logic [OVW-1:0] ovf_count
);
  logic          fire;
  logic [CW-1:0] wc;
  assign fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) wc <= '0;
    else if (fire) wc <= out_last ? '0 : wc + 1'b1;
  end

  p_last_valid_r8: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  p_frame_len_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && out_last) |-> (wc == CW'(WIN)));
  p_header_tag_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && wc == '0) |-> (out_data[OW-1 -: FW] == HDR_TAG));
  p_data_sel_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && wc != '0) |-> out_data[DW]);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  p_ovf_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(ovf_count) |-> (ovf_count == $past(ovf_count) + 1'b1));
endmodule

bind trig_sample_buf tsb_chk #(
  .DW(DW), .FW(FW), .PRE(PRE), .POST(POST), .OVW(OVW), .HDR_TAG(HDR_TAG)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .ovf_count(ovf_count)
);

// File: tb/sim_trig_sample_buf.sv
`timescale 1ns/1ps
module sim_trig_sample_buf;
  localparam int DW = 16, FW = 8, TW = 12, EW = 4, PRE = 2, POST = 3;
  localparam int WIN = PRE + POST + 1, OW = DW + FW, OVW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic l0_valid = 1'b0;
  logic [TW-1:0] l0_time = '0;
  logic l1_valid = 1'b0;
  logic [EW-1:0] l1_evnum = '0;
  logic l1_accept = 1'b0;
  logic out_ready = 1'b1;
  logic out_valid, out_last;
  logic [OW-1:0] out_data;
  logic [OVW-1:0] ovf_count;

  trig_sample_buf u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .l0_valid(l0_valid), .l0_time(l0_time), .l1_valid(l1_valid),
    .l1_evnum(l1_evnum), .l1_accept(l1_accept), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .ovf_count(ovf_count)
  );

  int nchk = 0, nfail = 0;
  int bt = 0;
  bit feed = 0;
  logic [OW-1:0] rxd[$];
  logic rxl[$];
  int rxp = 0;

  function automatic logic [DW-1:0] smp_fn(int t);
    return DW'(t * 37 + 11);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // sample source: one sample per cycle, timestamp = index since reset
  initial forever begin
    @(negedge clk);
    if (feed) begin
      smp_valid = 1'b1;
      smp_data  = smp_fn(bt);
      bt++;
    end else smp_valid = 1'b0;
  end

  // output monitor: record every handshake
  initial forever begin
    @(negedge clk); #1;
    if (!rst && out_valid && out_ready) begin
      rxd.push_back(out_data);
      rxl.push_back(out_last);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_l0(int t);
    @(negedge clk);
    l0_valid = 1'b1; l0_time = TW'(t);
    @(negedge clk);
    l0_valid = 1'b0;
  endtask

  task automatic send_l1(int ev, bit acc);
    @(negedge clk);
    l1_valid = 1'b1; l1_evnum = EW'(ev); l1_accept = acc;
    @(negedge clk);
    l1_valid = 1'b0;
  endtask

  task automatic expect_event(string req, int ev, int t);
    int guard = 0;
    while (rxd.size() < rxp + WIN + 1 && guard < 200) begin
      @(negedge clk); guard++;
    end
    chk(req, "event words present", 32'(rxd.size() >= rxp + WIN + 1), 32'd1);
    if (rxd.size() < rxp + WIN + 1) return;
    chk("R8", "header", 32'(rxd[rxp]), {8'h00, 8'hE0, 4'(ev), 12'(t)});
    chk("R10", "event number", 32'(rxd[rxp][15:12]), 32'(ev[3:0]));
    chk("R8", "header not last", 32'(rxl[rxp]), 32'd0);
    for (int k = 0; k < WIN; k++) begin
      chk("R2", "sample", 32'(rxd[rxp+1+k][15:0]), 32'(smp_fn(t - PRE + k)));
      chk("R3", "flags", 32'(rxd[rxp+1+k][23:16]), (k == PRE) ? 32'h03 : 32'h01);
      chk("R8", "last marker", 32'(rxl[rxp+1+k]), 32'(k == WIN - 1));
    end
    rxp += WIN + 1;
  endtask

  task automatic t_reset();
    wait_cyc(3); #1;
    chk("R11", "out_valid in reset", 32'(out_valid), 32'd0);
    @(negedge clk); rst = 1'b0;
    wait_cyc(2); #1;
    chk("R11", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R11", "out_last after reset", 32'(out_last), 32'd0);
    chk("R11", "ovf after reset", 32'(ovf_count), 32'd0);
  endtask

  task automatic t_accept();
    int t;
    feed = 1;
    wait_cyc(120);                 // ring has wrapped (R1)
    t = bt - 10;
    send_l0(t);
    wait_cyc(40); #1;
    chk("R4", "no output before L1", 32'(rxd.size()), 32'(rxp));
    send_l1(0, 1'b1);
    expect_event("R1", 0, t);
  endtask

  task automatic t_reject();
    int t;
    send_l0(bt - 10);
    wait_cyc(20);
    send_l1(1, 1'b0);
    wait_cyc(40); #1;
    chk("R5", "no output on reject", 32'(rxd.size()), 32'(rxp));
    t = bt - 12;
    send_l0(t);
    wait_cyc(20);
    send_l1(2, 1'b1);
    expect_event("R5", 2, t);
  endtask

  task automatic t_mismatch();
    int t;
    send_l1(5, 1'b1);              // nothing stored
    wait_cyc(10);
    t = bt - 10;
    send_l0(t);
    wait_cyc(20);
    send_l1(9, 1'b1);              // oldest undecided is 3
    wait_cyc(40); #1;
    chk("R6", "wrong number ignored", 32'(rxd.size()), 32'(rxp));
    send_l1(3, 1'b1);
    expect_event("R6", 3, t);
  endtask

  task automatic t_overflow();
    int ta, tc, td, te;
    ta = bt - 10;
    @(negedge clk); l0_valid = 1'b1; l0_time = TW'(ta);
    @(negedge clk); l0_time = TW'(bt - 20);   // capture still busy
    @(negedge clk); l0_valid = 1'b0;
    wait_cyc(30); #1;
    chk("R7", "drop while busy", 32'(ovf_count), 32'd1);
    tc = bt - 10; send_l0(tc); wait_cyc(30);
    td = bt - 11; send_l0(td); wait_cyc(30);
    te = bt - 12; send_l0(te); wait_cyc(30);
    send_l0(bt - 10);              // all four slots held
    wait_cyc(5); #1;
    chk("R7", "drop when full", 32'(ovf_count), 32'd2);
    chk("R4", "held events silent", 32'(rxd.size()), 32'(rxp));
    send_l1(4, 1'b1); send_l1(5, 1'b1); send_l1(6, 1'b1); send_l1(7, 1'b1);
    expect_event("R7", 4, ta);
    expect_event("R10", 5, tc);
    expect_event("R10", 6, td);
    expect_event("R10", 7, te);
  endtask

  task automatic t_backpressure();
    int t;
    logic [OW-1:0] h;
    out_ready = 1'b0;
    t = bt - 10;
    send_l0(t);
    wait_cyc(20);
    send_l1(8, 1'b1);
    wait_cyc(20); #1;
    chk("R9", "valid while stalled", 32'(out_valid), 32'd1);
    h = out_data;
    wait_cyc(5); #1;
    chk("R9", "valid held", 32'(out_valid), 32'd1);
    chk("R9", "data held", 32'(out_data), 32'(h));
    chk("R9", "held word is header", 32'(h), {8'h00, 8'hE0, 4'd8, 12'(t)});
    @(negedge clk); out_ready = 1'b1;
    expect_event("R9", 8, t);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_accept();
    t_reject();
    t_mismatch();
    t_overflow();
    t_backpressure();
    wait_cyc(10);
    finish_run();
  end
endmodule